// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block produces the periodic event strobe of a PC-style real-time clock. It counts enable pulses of a 32.768 kHz reference and, according to a 4-bit rate code held in a frequency-select byte, emits a strobe at one of fifteen power-of-two rates between 32768 Hz and 2 Hz. Rate code 0 stops the strobe. The strobe sets the periodic flag unconditionally, so it carries no enable of its own. The flag register and any interrupt masking sit downstream of this block.

Software writes the frequency-select byte through a single-cycle write port. The byte has two fields. Bits [3:0] hold the rate code. Bits [6:4] hold a divider-control field, and the prescaler runs only when that field holds the 32.768 kHz selection `3'b010`. Any write restarts the period phase, so the first strobe after a write comes a full period later and never early.

Top module: `rtc_periodic_divider`

## Requirements
- R1: After reset the rate code is 6 and the divider-control field is `3'b010`. `tick_out` is low, and without any write a strobe follows every 32nd reference tick (1024 Hz).
- R2: With rate code 0, `tick_out` stays low whatever the reference ticks do.
- R3: With rate code n from 1 to 15 and the divider running, one strobe is emitted for every 2^(n-1) reference ticks. This is 2^(16-n) Hz, so n=1 strobes on every tick and n=15 gives 2 Hz.
- R4: A write clears the period phase. The first strobe after a write comes on the 2^(n-1)-th reference tick after it, even when the write lands partway through a period.
- R5: While bits [6:4] of the written byte differ from `3'b010`, the prescaler is held at zero and no strobe is emitted. Writing `3'b010` back resumes counting from phase zero.
- R6: Bit 7 of the written byte has no effect on the strobe rate or phase.
- R7: `tick_out` is high for exactly one clock, in the cycle after the clock edge that samples an asserted `ref_tick`. It is never high unless `ref_tick` was high in the previous cycle.
- R8: A reference tick that arrives in the same cycle as a write is not counted and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the frequency-select byte |
| wr_data | input | 8 | Frequency-select byte: [3:0] rate code, [6:4] divider control, [7] unused |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| tick_out | output | 1 | Periodic event strobe, one clock wide |

## Verification
The checks assume `ref_tick` is a one-cycle enable and is never high in two consecutive clocks. Under that assumption a one-cycle-wide strobe is well defined even at rate code 1. The stimulus always places at least one idle clock between reference ticks, with a random number of extra idle clocks. Writes are single-cycle pulses. One directed case aligns a write with a reference tick to cover the case where both arrive in the same cycle.

// File: rtl/rtc_periodic_divider.sv
module rtc_periodic_divider #(
  parameter int          CNT_W      = 15,
  parameter logic [3:0]  RESET_RATE = 4'd6,
  parameter logic [2:0]  BASE_SEL   = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ref_tick,
  output logic       tick_out
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [3:0]       rate_q;
  logic [2:0]       div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  wire run = (div_q == BASE_SEL);

  always_comb begin
    if (rate_q == 4'd0) mask = '0;
    else                mask = (ONE << (rate_q - 4'd1)) - ONE;
  end

  wire hit = run && (rate_q != 4'd0) && ref_tick && !wr_en && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q   <= RESET_RATE;
      div_q    <= BASE_SEL;
      cnt_q    <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= hit;
      if (wr_en) begin
        rate_q <= wr_data[3:0];
        div_q  <= wr_data[6:4];
        cnt_q  <= '0;
      end else if (!run) begin
        cnt_q  <= '0;
      end else if (ref_tick) begin
        cnt_q  <= cnt_q + ONE;
      end
    end
  end

endmodule

// File: rtl/rtc_periodic_divider_chk.sv
module rtc_periodic_divider_chk #(
  parameter logic [2:0] BASE_SEL = 3'b010
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       ref_tick,
  input logic [3:0] rate_q,
  input logic [2:0] div_q,
  input logic       tick_out
);

  p_strobe_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> $past(ref_tick));

  p_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> !tick_out);

  p_write_swallows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> !$past(wr_en));

  p_zero_rate_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 4'd0) |=> !tick_out);

  p_halted_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != BASE_SEL) |=> !tick_out);

  p_fastest_every_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 4'd1 && div_q == BASE_SEL && ref_tick && !wr_en) |=> tick_out);

endmodule

bind rtc_periodic_divider rtc_periodic_divider_chk #(.BASE_SEL(BASE_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ref_tick(ref_tick),
  .rate_q(rate_q), .div_q(div_q), .tick_out(tick_out)
);

// File: tb/rtc_periodic_divider_bench.sv
module rtc_periodic_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] BASE = 3'b010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic ref_tick = 1'b0;
  logic tick_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_periodic_divider u_rtc_periodic_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ref_tick(ref_tick), .tick_out(tick_out)
  );

  function automatic int period_of(input int n);
    return 1 << (n - 1);
  endfunction

  function automatic bit expect_strobe(input int n, input bit running, input int k);
    if (n == 0 || !running) return 1'b0;
    return (k % period_of(n)) == 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic window(input int n, input bit running, input int t, input int gapmax, input string req);
    int errs = 0;
    int first_act = 0;
    int first_exp = 0;
    for (int k = 1; k <= t; k++) begin
      bit e;
      int g;
      @(negedge clk);
      ref_tick = 1'b1;
      @(negedge clk);
      e = expect_strobe(n, running, k);
      if (tick_out !== e) begin
        if (errs == 0) begin first_act = int'(tick_out); first_exp = int'(e); end
        errs++;
      end
      ref_tick = 1'b0;
      g = (gapmax > 0) ? int'($urandom_range(0, gapmax)) : 0;
      for (int i = 0; i < g; i++) begin
        @(negedge clk);
        if (tick_out !== 1'b0) begin
          if (errs == 0) begin first_act = 1; first_exp = 0; end
          errs++;
        end
      end
    end
    check(errs == 0, req, first_act, first_exp);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick_out === 1'b0, "R1 reset strobe low", int'(tick_out), 0);
    window(6, 1'b1, 96, 2, "R1 default 1024 Hz");

    write_reg({1'b0, BASE, 4'd1});
    check(tick_out === 1'b0, "R4 no strobe on write", int'(tick_out), 0);
    window(1, 1'b1, 20, 2, "R3 rate 1 every tick");
    write_reg({1'b0, BASE, 4'd15});
    window(15, 1'b1, 16384, 0, "R3 rate 15 period 16384");

    write_reg({1'b0, BASE, 4'd0});
    window(0, 1'b1, 200, 3, "R2 rate 0 silent");

    write_reg({1'b0, 3'b000, 4'd3});
    window(3, 1'b0, 100, 2, "R5 divider held");
    write_reg({1'b0, 3'b110, 4'd2});
    window(2, 1'b0, 50, 2, "R5 other divider code held");
    write_reg({1'b0, BASE, 4'd3});
    window(3, 1'b1, 40, 2, "R5 resume from phase zero");

    write_reg({1'b1, BASE, 4'd4});
    window(4, 1'b1, 64, 2, "R6 bit 7 ignored");

    write_reg({1'b0, BASE, 4'd5});
    window(5, 1'b1, 7, 1, "R4 partial period");
    write_reg({1'b0, BASE, 4'd5});
    window(5, 1'b1, 48, 1, "R4 phase restarted");

    @(negedge clk);
    wr_en = 1'b1; wr_data = {1'b0, BASE, 4'd2}; ref_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ref_tick = 1'b0;
    check(tick_out === 1'b0, "R8 coincident tick no strobe", int'(tick_out), 0);
    window(2, 1'b1, 10, 1, "R8 coincident tick not counted");

    for (int it = 0; it < 20; it++) begin
      int n = int'($urandom_range(0, 9));
      int t = int'($urandom_range(1, 300));
      write_reg({1'(($urandom) & 1), BASE, 4'(n)});
      window(n, 1'b1, t, 2, "R3 random rate");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule